// File: doc/BRIEF.md
# Over-Temperature Monitor Control and Status Register

This block is a single byte-wide register on a simple peripheral bus: address, write strobe, write data and combinational read data. It holds the controls for an on-chip over-temperature monitor. These are a sensor enable, an enable that routes an internal voltage onto a converter channel, and a choice between a temperature-proportional voltage and a bandgap reference for that routing. From these controls it drives the sensor enable and a channel-routing code for the analog multiplexer.

The comparator output from the sensor arrives asynchronously. The register resynchronizes it and shows it as a read-only status bit. Any change of that status, in either direction, sets a sticky flag. Software clears the flag by writing 1 to it. The flag raises an interrupt request when the interrupt enable is on. Two upper bits are reserved for test use and accept writes only while a test-mode input is high.

Top module: `thermal_alarm_csr`

## Requirements
- R1: After reset the read value at the register address is 0x00, `adc_route_o` is 0, `sensor_en_o` is 0 and `irq_o` is 0.
- R2: Bit positions, from bit 7 down to bit 0, are: reserved[1:0], volt_sel, volt_access, sensor_en, status, irq_en, flag. A write with `bus_addr` equal to `REG_ADDR` updates volt_sel, volt_access, sensor_en and irq_en from the write data. A write to any other address changes nothing. A read of any other address returns 0x00.
- R3: Bit 2 (status) ignores writes. With the sensor enabled, status reads the comparator level SYNC_STAGES+1 clock edges after that level is applied.
- R4: While sensor_en is 0, status reads 0 whatever the comparator level. `sensor_en_o` equals bit 3.
- R5: The flag (bit 0) becomes 1 one edge after status changes, on a 0-to-1 change and on a 1-to-0 change alike. This includes a fall caused by clearing sensor_en.
- R6: Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R7: When a status change and a write-1 clear reach the same clock edge, the flag ends at 1.
- R8: `irq_o` is 1 exactly while both flag and irq_en are 1.
- R9: `adc_route_o` is 0 (external input) when volt_access is 0. It is 1 (temperature voltage) when volt_access is 1 and volt_sel is 0. It is 2 (bandgap) when both are 1.
- R10: Bits 7:6 take the write data only while `test_mode_i` is 1. Otherwise they keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when the address does not match |
| test_mode_i | input | 1 | Unlocks writes to the reserved bits |
| comp_async_i | input | 1 | Asynchronous comparator level, 1 when above threshold |
| sensor_en_o | output | 1 | Enable for the analog sensor |
| adc_route_o | output | 2 | Converter channel routing code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with REG_ADDR set to 5 instead of the default 3. Writes to the default address can then be shown to have no effect, and the decode is checked on a value that is not the default. SYNC_STAGES stays at 2. The bench derives the arrival edge of status changes from that parameter. This lets it land a write-1 clear on the exact edge where a flag-set event happens, which the set-wins rule needs.

// File: rtl/talarm_pkg.sv
package talarm_pkg;

    localparam int CSR_W = 8;

    localparam int B_FLAG   = 0;
    localparam int B_IE     = 1;
    localparam int B_STATUS = 2;
    localparam int B_EN     = 3;
    localparam int B_VAE    = 4;
    localparam int B_VSEL   = 5;
    localparam int B_RSV_LO = 6;

    typedef enum logic [1:0] {
        ROUTE_EXT  = 2'd0,
        ROUTE_TEMP = 2'd1,
        ROUTE_BG   = 2'd2
    } route_t;

    typedef struct packed {
        logic [1:0] rsv;
        logic       vsel;
        logic       vae;
        logic       en;
        logic       ie;
    } ctrl_t;

    function automatic route_t pick_route(input logic vae, input logic vsel);
        if (!vae)
            return ROUTE_EXT;
        return vsel ? ROUTE_BG : ROUTE_TEMP;
    endfunction

endpackage

// File: rtl/talarm_sync.sv
module talarm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/talarm_flag.sv
module talarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic status_i,
    input  logic clr_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic change;

    assign change = status_i ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= status_i;
            if (change)
                flag_q <= 1'b1;
            else if (clr_i)
                flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/thermal_alarm_csr.sv
module thermal_alarm_csr
    import talarm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int REG_ADDR    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              test_mode_i,
    input  logic              comp_async_i,
    output logic              sensor_en_o,
    output logic [1:0]        adc_route_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    ctrl_t ctrl_q;
    logic  comp_sync;
    logic  status_q;
    logic  flag_q;
    logic  addr_hit;
    logic  wr_hit;
    logic  flag_clr;
    route_t route;

    assign addr_hit = (bus_addr == MY_ADDR);
    assign wr_hit   = bus_we && addr_hit;
    assign flag_clr = wr_hit && bus_wdata[B_FLAG];

    talarm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (comp_async_i),
        .q_sync  (comp_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q.vsel <= bus_wdata[B_VSEL];
            ctrl_q.vae  <= bus_wdata[B_VAE];
            ctrl_q.en   <= bus_wdata[B_EN];
            ctrl_q.ie   <= bus_wdata[B_IE];
            if (test_mode_i)
                ctrl_q.rsv <= bus_wdata[B_RSV_LO+1:B_RSV_LO];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= ctrl_q.en & comp_sync;
    end

    talarm_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_q),
        .clr_i    (flag_clr),
        .flag_o   (flag_q)
    );

    assign route = pick_route(ctrl_q.vae, ctrl_q.vsel);

    always_comb begin
        bus_rdata = '0;
        if (addr_hit) begin
            bus_rdata[B_RSV_LO+1:B_RSV_LO] = ctrl_q.rsv;
            bus_rdata[B_VSEL]   = ctrl_q.vsel;
            bus_rdata[B_VAE]    = ctrl_q.vae;
            bus_rdata[B_EN]     = ctrl_q.en;
            bus_rdata[B_STATUS] = status_q;
            bus_rdata[B_IE]     = ctrl_q.ie;
            bus_rdata[B_FLAG]   = flag_q;
        end
    end

    assign sensor_en_o = ctrl_q.en;
    assign adc_route_o = route;
    assign irq_o       = flag_q & ctrl_q.ie;
endmodule

// File: rtl/talarm_checker.sv
module talarm_checker (
    input logic       clk,
    input logic       rst,
    input logic       status,
    input logic       flag,
    input logic       clr_wr,
    input logic       en,
    input logic       ie,
    input logic       vae,
    input logic [1:0] rsv,
    input logic       test_mode,
    input logic       irq,
    input logic [1:0] route
);
    assert_flag_on_change_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |=> flag);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr) |=> flag);

    assert_status_gated_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> !status);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

    assert_route_external_R9: assert property (@(posedge clk) disable iff (rst)
        !vae |-> (route == 2'd0));

    assert_rsv_locked_R10: assert property (@(posedge clk) disable iff (rst)
        !test_mode |=> $stable(rsv));
endmodule

bind thermal_alarm_csr talarm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .status    (status_q),
    .flag      (flag_q),
    .clr_wr    (flag_clr),
    .en        (ctrl_q.en),
    .ie        (ctrl_q.ie),
    .vae       (ctrl_q.vae),
    .rsv       (ctrl_q.rsv),
    .test_mode (test_mode_i),
    .irq       (irq_o),
    .route     (adc_route_o)
);

// File: tb/sim_thermal_alarm_csr.sv
`timescale 1ns/1ps
module sim_thermal_alarm_csr;
    localparam int AW   = 4;
    localparam int ADDR = 5;
    localparam int SYNC = 2;
    localparam logic [AW-1:0] A = AW'(ADDR);
    localparam logic [AW-1:0] A_OTHER = AW'(3);

    logic clk = 0, rst = 1;
    logic [AW-1:0] bus_addr = A;
    logic bus_we = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic test_mode_i = 0, comp_async_i = 0;
    logic sensor_en_o, irq_o;
    logic [1:0] adc_route_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    thermal_alarm_csr #(.ADDR_W(AW), .REG_ADDR(ADDR), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .test_mode_i(test_mode_i),
        .comp_async_i(comp_async_i), .sensor_en_o(sensor_en_o),
        .adc_route_o(adc_route_o), .irq_o(irq_o)
    );

    // {wdata, test_mode, expected read, expected route}, comparator held low
    localparam logic [18:0] VEC [7] = '{
        {8'h3F, 1'b0, 8'h3A, 2'd2},
        {8'h10, 1'b0, 8'h10, 2'd1},
        {8'h20, 1'b0, 8'h20, 2'd0},
        {8'hC0, 1'b1, 8'hC0, 2'd0},
        {8'h00, 1'b0, 8'hC0, 2'd0},
        {8'h04, 1'b1, 8'h00, 2'd0},
        {8'h08, 1'b0, 8'h08, 2'd0}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic tm);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d; test_mode_i = tm;
        @(negedge clk);
        bus_we = 0; test_mode_i = 0; bus_addr = A;
    endtask

    task automatic rd(output logic [7:0] v);
        bus_addr = A; #0.5; v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst = 0;
        @(negedge clk);
        rd(v); chk("R1 read", v, 8'h00);
        chk("R1 route", {6'd0, adc_route_o}, 8'h00);
        chk("R1 en/irq", {6'd0, sensor_en_o, irq_o}, 8'h00);

        // vector table: R2 R9 R10 and status write ignored R3
        foreach (VEC[i]) begin
            wr(A, VEC[i][18:11], VEC[i][10]);
            rd(v); chk("R2/R10 table read", v, VEC[i][9:2]);
            chk("R9 table route", {6'd0, adc_route_o}, {6'd0, VEC[i][1:0]});
            chk("R8 table irq", {7'd0, irq_o}, 8'h00);
        end
        chk("R4 sensor_en_o", {7'd0, sensor_en_o}, 8'h01);

        // R2: other address ignored and reads zero
        wr(A_OTHER, 8'h3A, 1'b1);
        rd(v); chk("R2 other-addr write ignored", v, 8'h08);
        bus_addr = A_OTHER; #0.5;
        chk("R2 other-addr read", bus_rdata, 8'h00);
        bus_addr = A;

        // R3: status appears SYNC+1 edges after comparator rises
        @(negedge clk); comp_async_i = 1;
        idle(SYNC);
        rd(v); chk("R3 status not yet", v & 8'h04, 8'h00);
        idle(1);
        rd(v); chk("R3 status up", v & 8'h04, 8'h04);
        idle(1);
        rd(v); chk("R5 flag on rise", v & 8'h01, 8'h01);
        chk("R8 irq off without ie", {7'd0, irq_o}, 8'h00);

        // R8: enable interrupt, write 0 to flag keeps it (R6)
        wr(A, 8'h0A, 1'b0);
        rd(v); chk("R6 write0 keeps flag", v, 8'h0F);
        chk("R8 irq on", {7'd0, irq_o}, 8'h01);
        wr(A, 8'h0B, 1'b0);
        rd(v); chk("R6 write1 clears", v, 8'h0E);
        chk("R8 irq drops", {7'd0, irq_o}, 8'h00);

        // R7: clear lands on the same edge as the falling-change set
        @(negedge clk); comp_async_i = 0;
        idle(SYNC);
        wr(A, 8'h0B, 1'b0);
        rd(v); chk("R7 set wins over clear", v, 8'h0B);
        wr(A, 8'h0B, 1'b0);
        rd(v); chk("R6 clear after collision", v, 8'h0A);

        // R5/R4: disabling the sensor drops status and sets flag
        @(negedge clk); comp_async_i = 1;
        idle(SYNC + 3);
        wr(A, 8'h0B, 1'b0);
        rd(v); chk("R3 status high again", v, 8'h0E);
        wr(A, 8'h02, 1'b0);
        idle(2);
        rd(v); chk("R4/R5 disable forces 0 and flags", v, 8'h03);
        chk("R4 sensor_en_o off", {7'd0, sensor_en_o}, 8'h00);
        wr(A, 8'h03, 1'b0);
        idle(SYNC + 2);
        rd(v); chk("R4 status stays 0 while disabled", v, 8'h02);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule